// File: doc/BRIEF.md
# Sparse Extended-Register Port/Memory Alias Decoder

This block sits on the bus side of a legacy graphics controller. It lets a sparse set of extended registers be reached either by I/O port writes or, once a control bit is set, through a fixed memory window. It watches a classic index/data port pair to capture one control register whose bit 4 turns the memory-mapped path on. Every accepted register write leaves the block as a single-cycle strobe carrying the register group, the register select nibble and the 16-bit data. Pixel-data writes, from a memory range or from two dedicated ports, leave the block as a separate single-cycle pulse.

The extended registers live at ports whose low byte is `0xE8` and whose top two address bits are `10`. Address bits 13:12 pick one of four groups, and bits 11:8 pick the register within the group. The memory alias of such a port is `0xA0000` plus the 16-bit port number. The alias is write-only. One register, a read-select register, is kept out of the window. For older systems, an input makes the index/data pair decode only the low 10 port address bits.

Top module: `sparse_alias_dec`

## Requirements
- R1: After reset, the control register is 0. `mm_on` is low, and `reg_we` and `pix_valid` are low until an accepted write occurs.
- R2: A port write to `0x03D4` latches `wr_data[7:0]` as the index. A port write to `0x03D5` while the index is `0x53` loads `wr_data[7:0]` into the control register. `mm_on` equals control bit 4 from the cycle after that write. A data write under any other index leaves `mm_on` unchanged.
- R3: When `legacy10` is high, the index/data ports are matched on `io_addr[9:0]` only, so for example `0x07D4` acts as `0x03D4`. When `legacy10` is low, all 16 bits must match.
- R4: A port write to an address with `io_addr[15:14]=2'b10` and `io_addr[7:0]=0xE8` produces, in the next cycle, one `reg_we` pulse. The pulse carries `reg_grp=io_addr[13:12]`, `reg_sel=io_addr[11:8]` and `reg_data=wr_data`. This happens whatever the value of `mm_on`.
- R5: While `mm_on` is high, a memory write (`mem_rd` low) to `mem_addr[19:16]=0xA` whose low 16 bits form a valid extended-register port (as in R4) produces the same strobe as the equivalent port write.
- R6: While `mm_on` is low, memory writes produce neither `reg_we` nor `pix_valid`.
- R7: A memory write to `0xABEE8` with `wr_data[15:12]=0xF` is ignored. A port write to `0xBEE8` with the same data is accepted.
- R8: A memory cycle with `mem_rd` high never produces `reg_we` or `pix_valid`, even if `mem_wr` is also high.
- R9: A port write to `0xE2E8` or `0xE2EA` produces `pix_valid` with `pix_data=wr_data` in the next cycle. With `mm_on` high, a memory write in `0xA0000`–`0xA7FFF` does the same.
- R10: When `io_wr` and `mem_wr` are both high in one cycle, the port access is served and the memory access is dropped.
- R11: Outputs are registered. A strobe or pulse lasts one cycle for each accepted write and is low in any cycle that follows a cycle with no accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy10 | input | 1 | Decode the index/data ports on 10 address bits |
| io_wr | input | 1 | Port write this cycle |
| io_addr | input | 16 | Port address |
| mem_wr | input | 1 | Memory write this cycle |
| mem_rd | input | 1 | Memory read this cycle |
| mem_addr | input | 20 | Memory address |
| wr_data | input | 16 | Write data for port or memory access |
| mm_on | output | 1 | Memory-mapped mode enabled |
| reg_we | output | 1 | Register-file write strobe |
| reg_grp | output | 2 | Register group (port bits 13:12) |
| reg_sel | output | 4 | Register select (port bits 11:8) |
| reg_data | output | 16 | Register write data |
| pix_valid | output | 1 | Pixel data valid pulse |
| pix_data | output | 16 | Pixel data |

## Verification
A wrong index or control register value shows at the ports on two occasions. The first is `mm_on` itself, which is visible one cycle after the data-port write. The second is the next memory write into the window, which either appears as a strobe or fails to. A stale or wrong select latch shows as a wrong `reg_grp` or `reg_sel` in the cycle after the offending write. A missed exclusion or read qualification shows as a spurious pulse on that same following cycle.

// File: rtl/sparse_alias_dec.sv
module sparse_alias_dec #(
  parameter int DW       = 16,
  parameter int MAW      = 20,
  parameter logic [7:0] CTRL_IDX = 8'h53,
  parameter int MM_BIT   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           legacy10,
  input  logic           io_wr,
  input  logic [15:0]    io_addr,
  input  logic           mem_wr,
  input  logic           mem_rd,
  input  logic [MAW-1:0] mem_addr,
  input  logic [DW-1:0]  wr_data,
  output logic           mm_on,
  output logic           reg_we,
  output logic [1:0]     reg_grp,
  output logic [3:0]     reg_sel,
  output logic [DW-1:0]  reg_data,
  output logic           pix_valid,
  output logic [DW-1:0]  pix_data
);
  logic [7:0] idx_q, ctrl_q;

  wire [15:0] io_cmp  = legacy10 ? {6'b0, io_addr[9:0]} : io_addr;
  wire        io_idx  = io_wr && io_cmp == 16'h03D4;
  wire        io_dat  = io_wr && io_cmp == 16'h03D5;
  wire        io_ext  = io_wr && io_addr[15:14] == 2'b10 && io_addr[7:0] == 8'hE8;
  wire        io_pix  = io_wr && (io_addr == 16'hE2E8 || io_addr == 16'hE2EA);

  wire        mem_ok  = mem_wr && !mem_rd && !io_wr && mm_on;
  wire        mem_ext = mem_ok && mem_addr[MAW-1:16] == 4'hA &&
                        mem_addr[15:14] == 2'b10 && mem_addr[7:0] == 8'hE8 &&
                        !(mem_addr[15:8] == 8'hBE && wr_data[DW-1:DW-4] == 4'hF);
  wire        mem_pix = mem_ok && mem_addr[MAW-1:15] == 5'b10100;

  wire [15:0] sel_src = io_wr ? io_addr : mem_addr[15:0];

  assign mm_on = ctrl_q[MM_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      ctrl_q    <= '0;
      reg_we    <= 1'b0;
      reg_grp   <= '0;
      reg_sel   <= '0;
      reg_data  <= '0;
      pix_valid <= 1'b0;
      pix_data  <= '0;
    end else begin
      if (io_idx) idx_q <= wr_data[7:0];
      if (io_dat && idx_q == CTRL_IDX) ctrl_q <= wr_data[7:0];
      reg_we    <= io_ext || mem_ext;
      pix_valid <= io_pix || mem_pix;
      if (io_ext || mem_ext) begin
        reg_grp  <= sel_src[13:12];
        reg_sel  <= sel_src[11:8];
        reg_data <= wr_data;
      end
      if (io_pix || mem_pix) pix_data <= wr_data;
    end
  end
endmodule

module sparse_alias_dec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_wr,
  input logic [15:0] io_addr,
  input logic        mem_wr,
  input logic        mem_rd,
  input logic [19:0] mem_addr,
  input logic [15:0] wr_data,
  input logic        mm_on,
  input logic        reg_we,
  input logic        pix_valid,
  input logic [15:0] reg_data
);
  p_mm_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mm_on) |-> $past(io_wr));
  p_port_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(io_wr && io_addr[15:14] == 2'b10 && io_addr[7:0] == 8'hE8) |-> reg_we && reg_data == $past(wr_data));
  p_mm_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!io_wr && !mm_on) |-> !reg_we && !pix_valid);
  p_excluded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!io_wr && mem_addr[15:0] == 16'hBEE8 && wr_data[15:12] == 4'hF) |-> !reg_we);
  p_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!io_wr && mem_rd) |-> !reg_we && !pix_valid);
  p_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!io_wr && !mem_wr) |-> !reg_we && !pix_valid);
endmodule

bind sparse_alias_dec sparse_alias_dec_chk i_chk (.*);

// File: tb/test_sparse_alias_dec.sv
module test_sparse_alias_dec;
  logic clk = 0, rst_n = 0, legacy10 = 0;
  logic io_wr = 0, mem_wr = 0, mem_rd = 0;
  logic [15:0] io_addr = 0, wr_data = 0;
  logic [19:0] mem_addr = 0;
  logic mm_on, reg_we, pix_valid;
  logic [1:0] reg_grp;
  logic [3:0] reg_sel;
  logic [15:0] reg_data, pix_data;

  int checks = 0, errors = 0;
  logic [7:0] m_idx = 0, m_ctrl = 0;

  always #10 clk = ~clk;

  sparse_alias_dec i_sparse_alias_dec (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic is_ext(logic [15:0] a);
    return a[15:14] == 2'b10 && a[7:0] == 8'hE8;
  endfunction

  task automatic cyc(string tag, logic iw, logic [15:0] ia, logic mw, logic mr,
                     logic [19:0] ma, logic [15:0] d);
    logic [15:0] cmp;
    logic mok, e_we, e_pv;
    logic [15:0] src;
    @(negedge clk);
    io_wr = iw; io_addr = ia; mem_wr = mw; mem_rd = mr; mem_addr = ma; wr_data = d;
    cmp  = legacy10 ? {6'b0, ia[9:0]} : ia;
    mok  = mw && !mr && !iw && m_ctrl[4];
    e_we = (iw && is_ext(ia)) ||
           (mok && ma[19:16] == 4'hA && is_ext(ma[15:0]) && !(ma[15:0] == 16'hBEE8 && d[15:12] == 4'hF));
    e_pv = (iw && (ia == 16'hE2E8 || ia == 16'hE2EA)) || (mok && ma[19:15] == 5'b10100);
    src  = iw ? ia : ma[15:0];
    @(posedge clk); #2;
    if (iw && cmp == 16'h03D5 && m_idx == 8'h53) m_ctrl = d[7:0];
    if (iw && cmp == 16'h03D4) m_idx = d[7:0];
    io_wr = 0; mem_wr = 0; mem_rd = 0;
    check({tag, " reg_we"}, reg_we, e_we);
    check({tag, " pix_valid"}, pix_valid, e_pv);
    check({tag, " mm_on R2"}, mm_on, m_ctrl[4]);
    if (e_we) check({tag, " strobe fields"}, {reg_grp, reg_sel, reg_data}, {src[13:12], src[11:8], d});
    if (e_pv) check({tag, " pix_data R9"}, pix_data, d);
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #2;
    check("R1 mm_on reset", mm_on, 0);
    check("R1 reg_we reset", reg_we, 0);
    check("R1 pix_valid reset", pix_valid, 0);
    rst_n = 1;
    cyc("R6 mem write while off", 0, 0, 1, 0, 20'hA8AE8, 16'h1111);
    cyc("R4 port BEE8 F-index", 1, 16'hBEE8, 0, 0, 0, 16'hF00F);
    cyc("R4 port 9CE8", 1, 16'h9CE8, 0, 0, 0, 16'h5A5A);
    cyc("R2 other index", 1, 16'h03D4, 0, 0, 0, 16'h0052);
    cyc("R2 data under other index", 1, 16'h03D5, 0, 0, 0, 16'h00FF);
    cyc("R3 alias ignored full decode", 1, 16'h07D4, 0, 0, 0, 16'h0053);
    cyc("R3 data after ignored alias", 1, 16'h03D5, 0, 0, 0, 16'h0010);
    check("R3 mm stays off", mm_on, 0);
    legacy10 = 1;
    cyc("R3 alias index 10-bit", 1, 16'h07D4, 0, 0, 0, 16'h0053);
    cyc("R3 alias data 10-bit", 1, 16'hFFD5, 0, 0, 0, 16'h0010);
    check("R3 mm on via alias", mm_on, 1);
    legacy10 = 0;
    cyc("R5 mem A81E8", 0, 0, 1, 0, 20'hA81E8, 16'h2468);
    cyc("R5 mem B3E8 group3", 0, 0, 1, 0, 20'hAB3E8, 16'h0ACE);
    cyc("R7 mem BEE8 excluded", 0, 0, 1, 0, 20'hABEE8, 16'hF123);
    cyc("R7 mem BEE8 other index", 0, 0, 1, 0, 20'hABEE8, 16'h3123);
    cyc("R8 read in window", 0, 0, 0, 1, 20'hA81E8, 16'h7777);
    cyc("R8 read+write", 0, 0, 1, 1, 20'hA0010, 16'h7777);
    cyc("R9 mem pixel low", 0, 0, 1, 0, 20'hA0000, 16'hBEEF);
    cyc("R9 mem pixel top", 0, 0, 1, 0, 20'hA7FFF, 16'hCAFE);
    cyc("R9 mem A8000 not pixel", 0, 0, 1, 0, 20'hA8000, 16'hCAFE);
    cyc("R9 port E2EA", 1, 16'hE2EA, 0, 0, 0, 16'h0F0F);
    cyc("R10 port wins", 1, 16'h8DE8, 1, 0, 20'hA0004, 16'h4321);
    cyc("R10 port non-decoded drops mem", 1, 16'h1234, 1, 0, 20'hA0004, 16'h4321);
    cyc("R11 idle", 0, 0, 0, 0, 0, 0);
    repeat (400) begin
      logic [15:0] a, d;
      logic [19:0] m;
      int k;
      k = $urandom % 10;
      a = {2'b10, 2'($urandom), 4'($urandom), 8'hE8};
      d = 16'($urandom);
      if ($urandom % 4 == 0) d[15:12] = 4'hF;
      m = {4'hA, a};
      legacy10 = ($urandom % 3 == 0);
      case (k)
        0: cyc("R4 rand port", 1, a, 0, 0, 0, d);
        1, 2: cyc("R5 rand mem", 0, 0, 1, 0, m, d);
        3: cyc("R7 rand mem BEE8", 0, 0, 1, 0, 20'hABEE8, d);
        4: cyc("R9 rand pixel", 0, 0, 1, 0, {5'b10100, 15'($urandom)}, d);
        5: cyc("R2 rand index", 1, ($urandom % 2) ? 16'h03D4 : {6'($urandom), 10'h3D4}, 0, 0, 0,
               ($urandom % 2) ? 16'h0053 : d);
        6: cyc("R2 rand data", 1, ($urandom % 2) ? 16'h03D5 : {6'($urandom), 10'h3D5}, 0, 0, 0, d);
        7: cyc("R8 rand read", 0, 0, $urandom % 2 == 1, 1, m, d);
        8: cyc("R10 rand both", 1, a, 1, 0, m, d);
        default: cyc("R6 rand other mem", 0, 0, 1, 0, 20'($urandom), d);
      endcase
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule